// File: doc/BRIEF.md
# Periodic Interrupt Generator

This block produces a periodic timing flag for a processor subsystem. It counts bus cycles with its own counter. Each time the count reaches the end of the current period, it sets a status flag. The period is a base length of 2^BASE_LOG2 bus cycles, multiplied by a power of two that a 2-bit rate field selects. With the default base this gives 8192, 16384, 32768 or 65536 cycles.

Software reaches three registers through a small write/read port:
- a control register that holds the rate field,
- a mask register that holds the interrupt enable,
- a status register that holds the flag.

The flag is cleared by writing 1 to its bit. The interrupt request output is the flag qualified by the enable.

A rate change does not restart the count. The next boundary is still measured from the last one. If the new period is shorter than the count already reached, the counter runs on, wraps through zero and then stops at the new terminal value. It never stalls.

Top module: `rti_gen`

## Requirements
- R1: Reset (active-low `rst_n`, asynchronous) clears the rate field, the enable and the flag, and restarts the period counter from zero. While reset is held, every register reads 0 and `irq` is low.
- R2: For rate field value r, the period is 2^(BASE_LOG2+r) bus cycles. After reset is released, the flag first sets on clock edge 2^BASE_LOG2, and then again every period.
- R3: The flag is set only at a period boundary. Once set, it stays set until a clear write removes it.
- R4: A write to the status register (address 2) clears the flag only when data bit 0 is 1. Writing 0 to bit 0 leaves the flag unchanged. If the clear arrives in the same cycle as a boundary, the flag stays set.
- R5: A write to the control register (address 0, rate in data bits [1:0]) does not reset the counter and does not set the flag. The next boundary falls at the new period, measured from the last boundary.
- R6: If the rate is lowered while the count is already past the new terminal value, the counter keeps counting, wraps through zero at its full width of BASE_LOG2+3 bits, and then sets the flag on reaching the new terminal value.
- R7: `irq` is high exactly when the flag is set and the enable (address 1, data bit 0) is set.
- R8: The read port is combinational on the address:
  - address 0 returns the rate in [1:0];
  - address 1 returns the enable in bit 0;
  - address 2 returns the flag in bit 0;
  - address 3 returns 0;
  - unused bits read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock; one count per cycle |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe, sampled on the rising clock edge |
| bus_addr | input | 2 | Register select: 0 control, 1 mask, 2 status, 3 reserved |
| bus_wdata | input | 2 | Write data |
| bus_rdata | output | 2 | Read data for the selected register |
| irq | output | 1 | Interrupt request: flag AND enable |

## Verification
The assertions check, on every cycle, the following local cause-and-effect rules:
- a boundary returns the counter to zero;
- the flag rises only after a boundary and falls only after a clear write with bit 0 set;
- a boundary always leaves the flag set;
- the rate changes only on a control write;
- a control write never sets the flag.

Only the bench scenarios can show the absolute timing. This covers:
- the first boundary after reset;
- the period for each rate;
- a boundary placed from the last one after a rate change;
- the extra full-width wrap when the rate is lowered past the current count.

The bench also compares the interrupt output each cycle against an independent model.

// File: rtl/rti_pkg.sv
package rti_pkg;

    localparam int ADDR_W = 2;
    localparam int DATA_W = 2;
    localparam int RATE_W = 2;
    localparam int RATES  = 1 << RATE_W;

    typedef enum logic [ADDR_W-1:0] {
        SEL_CTRL = 2'd0,
        SEL_MASK = 2'd1,
        SEL_STAT = 2'd2,
        SEL_RSVD = 2'd3
    } reg_sel_e;

endpackage

// File: rtl/rti_period_cnt.sv
module rti_period_cnt
    import rti_pkg::*;
#(
    parameter int BASE_LOG2 = 13
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [RATE_W-1:0] rate,
    output logic              tick
);

    localparam int CNT_W = BASE_LOG2 + RATES - 1;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } cnt_st_t;

    cnt_st_t st_d, st_q;

    // Terminal value for each rate setting
    logic [CNT_W-1:0] term_tbl [RATES];

    for (genvar g = 0; g < RATES; g++) begin : g_term
        assign term_tbl[g] = CNT_W'((64'd1 << (BASE_LOG2 + g)) - 64'd1);
    end

    // A lowered rate with a larger count runs on and wraps at full width
    assign tick = (st_q.cnt == term_tbl[rate]);

    always_comb begin
        st_d = st_q;
        if (tick) begin
            st_d.cnt = '0;
        end else begin
            st_d.cnt = st_q.cnt + CNT_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // R2
    cnt_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> (st_q.cnt == '0));

endmodule

// File: rtl/rti_regs.sv
module rti_regs
    import rti_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic              tick,
    output logic [RATE_W-1:0] rate,
    output logic              enable,
    output logic              flag,
    output logic [DATA_W-1:0] bus_rdata
);

    typedef struct packed {
        logic [RATE_W-1:0] rate;
        logic              en;
        logic              flag;
    } reg_st_t;

    reg_st_t  st_d, st_q;
    reg_sel_e sel;

    assign sel = reg_sel_e'(bus_addr);

    always_comb begin
        st_d = st_q;
        if (bus_wr) begin
            case (sel)
                SEL_CTRL: st_d.rate = bus_wdata[RATE_W-1:0];
                SEL_MASK: st_d.en   = bus_wdata[0];
                SEL_STAT: if (bus_wdata[0]) st_d.flag = 1'b0;
                default:  ;
            endcase
        end
        // A boundary wins over a coincident clear
        if (tick) begin
            st_d.flag = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        bus_rdata = '0;
        case (sel)
            SEL_CTRL: bus_rdata = DATA_W'(st_q.rate);
            SEL_MASK: bus_rdata = DATA_W'(st_q.en);
            SEL_STAT: bus_rdata = DATA_W'(st_q.flag);
            default:  bus_rdata = '0;
        endcase
    end

    assign rate   = st_q.rate;
    assign enable = st_q.en;
    assign flag   = st_q.flag;

    // R3
    flag_set_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.flag) |-> $past(tick));

    // R4
    flag_clr_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(st_q.flag) |-> $past(bus_wr && sel == SEL_STAT && bus_wdata[0]));

    // R4
    set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> st_q.flag);

    // R5
    ctrl_noset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && sel == SEL_CTRL && !tick) |=> (st_q.flag == $past(st_q.flag)));

    // R5
    rate_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_wr && sel == SEL_CTRL) |=> $stable(st_q.rate));

endmodule

// File: rtl/rti_gen.sv
module rti_gen
    import rti_pkg::*;
#(
    parameter int BASE_LOG2 = 13
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq
);

    logic [RATE_W-1:0] rate;
    logic              tick;
    logic              enable;
    logic              flag;

    rti_period_cnt #(
        .BASE_LOG2 (BASE_LOG2)
    ) i_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .rate  (rate),
        .tick  (tick)
    );

    rti_regs i_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .tick      (tick),
        .rate      (rate),
        .enable    (enable),
        .flag      (flag),
        .bus_rdata (bus_rdata)
    );

    // R7
    assign irq = flag & enable;

endmodule

// File: tb/test_rti_gen.sv
module test_rti_gen;

    localparam int CLK_PERIOD = 10;
    localparam int B          = 6;
    localparam int FULL       = 1 << (B + 3);

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_wr = 1'b0;
    logic [1:0] bus_addr = 2'd0;
    logic [1:0] bus_wdata = 2'd0;
    logic [1:0] bus_rdata;
    logic       irq;

    int total = 0;
    int fails = 0;
    int cyc = 0;
    bit done = 1'b0;
    bit run_irq_chk = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    rti_gen #(.BASE_LOG2(B)) i_rti_gen (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .irq       (irq)
    );

    // Reference model built from the requirements
    int       m_cnt = 0;
    bit [1:0] m_rate = 2'd0;
    bit       m_en = 1'b0;
    bit       m_flag = 1'b0;

    function automatic int period(input bit [1:0] r);
        return 1 << (B + r);
    endfunction

    function automatic bit [1:0] exp_read(input bit [1:0] a);
        case (a)
            2'd0: return m_rate;
            2'd1: return {1'b0, m_en};
            2'd2: return {1'b0, m_flag};
            default: return 2'd0;
        endcase
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cyc    <= 0;
            m_cnt  <= 0;
            m_rate <= 2'd0;
            m_en   <= 1'b0;
            m_flag <= 1'b0;
        end else begin
            automatic bit bnd = (m_cnt == period(m_rate) - 1);
            automatic bit nf  = m_flag;
            cyc   <= cyc + 1;
            m_cnt <= bnd ? 0 : (m_cnt + 1) % FULL;
            if (bus_wr && bus_addr == 2'd0) m_rate <= bus_wdata;
            if (bus_wr && bus_addr == 2'd1) m_en <= bus_wdata[0];
            if (bus_wr && bus_addr == 2'd2 && bus_wdata[0]) nf = 1'b0;
            if (bnd) nf = 1'b1;
            m_flag <= nf;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    // R7: irq against the model on every cycle
    always @(negedge clk) begin
        if (rst_n && run_irq_chk) chk("R7 irq", {31'd0, irq}, {31'd0, m_flag & m_en});
    end

    task automatic rd(input logic [1:0] a, input logic [1:0] exp, input string req);
        bus_addr = a;
        #1;
        chk(req, {30'd0, bus_rdata}, {30'd0, exp});
    endtask

    task automatic wr(input logic [1:0] a, input logic [1:0] d);
        bus_wr = 1'b1;
        bus_addr = a;
        bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic goto(input int n);
        while (cyc < n) @(negedge clk);
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", total - fails, total);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            total++;
            fails++;
            $display("FAIL watchdog expired at cycle %0d", cyc);
            summary();
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        // R1: state while reset is held
        rd(2'd0, 2'd0, "R1 ctrl in reset");
        rd(2'd2, 2'd0, "R1 flag in reset");
        chk("R1 irq in reset", {31'd0, irq}, 32'd0);
        rst_n = 1'b1;
        run_irq_chk = 1'b1;
        rd(2'd1, 2'd0, "R8 mask after reset");
        rd(2'd3, 2'd0, "R8 reserved reads zero");

        // R2: first boundary at edge 2^B
        goto(63);  rd(2'd2, 2'd0, "R2 no flag before first boundary");
        goto(64);  rd(2'd2, 2'd1, "R2 flag at first boundary");
        chk("R7 irq masked", {31'd0, irq}, 32'd0);
        wr(2'd1, 2'd1);
        chk("R7 irq enabled", {31'd0, irq}, 32'd1);
        rd(2'd1, 2'd1, "R8 mask readback");
        wr(2'd2, 2'd1);
        rd(2'd2, 2'd0, "R4 clear by one");
        goto(127); rd(2'd2, 2'd0, "R3 flag stays clear mid period");
        goto(128); rd(2'd2, 2'd1, "R2 second boundary");

        // R4: clear coincident with boundary at 192
        goto(191); wr(2'd2, 2'd1);
        rd(2'd2, 2'd1, "R4 boundary wins over clear");
        wr(2'd2, 2'd0);
        rd(2'd2, 2'd1, "R4 zero write keeps flag");
        wr(2'd2, 2'd2);
        rd(2'd2, 2'd1, "R4 bit1 write keeps flag");
        wr(2'd2, 2'd1);
        rd(2'd2, 2'd0, "R4 bit0 write clears");

        // R5: rate 1 at edge 200, boundary measured from 192
        goto(199); wr(2'd0, 2'd1);
        rd(2'd2, 2'd0, "R5 ctrl write sets no flag");
        rd(2'd0, 2'd1, "R8 ctrl readback");
        goto(256); rd(2'd2, 2'd0, "R5 old period boundary gone");
        goto(319); rd(2'd2, 2'd0, "R5 before new boundary");
        goto(320); rd(2'd2, 2'd1, "R5 new boundary from last one");

        // R6: raise to rate 3, then lower to rate 0 with count 400
        wr(2'd2, 2'd1);
        wr(2'd0, 2'd3);
        goto(720); wr(2'd0, 2'd0);
        goto(832); rd(2'd2, 2'd0, "R6 no boundary at wrap point");
        goto(895); rd(2'd2, 2'd0, "R6 before wrapped boundary");
        goto(896); rd(2'd2, 2'd1, "R6 boundary after full wrap");

        // R1: reset in mid run
        @(negedge clk);
        rst_n = 1'b0;
        #1;
        rd(2'd0, 2'd0, "R1 ctrl cleared");
        rd(2'd1, 2'd0, "R1 mask cleared");
        rd(2'd2, 2'd0, "R1 flag cleared");
        chk("R1 irq low", {31'd0, irq}, 32'd0);
        @(negedge clk);
        rst_n = 1'b1;
        goto(63);  rd(2'd2, 2'd0, "R1 counter restarted");
        goto(64);  rd(2'd2, 2'd1, "R1 R2 boundary after second reset");

        // Random phase, R8 reads against the model
        for (int i = 0; i < 6000; i++) begin
            int r;
            @(negedge clk);
            r = int'($urandom % 100);
            bus_wr = 1'b0;
            if (r < 1) begin
                bus_wr = 1'b1; bus_addr = 2'd0;
            end else if (r < 4) begin
                bus_wr = 1'b1; bus_addr = 2'd1;
            end else if (r < 7) begin
                bus_wr = 1'b1; bus_addr = 2'd2;
            end else begin
                bus_addr = 2'($urandom);
            end
            bus_wdata = 2'($urandom);
            #1;
            chk("R8 random read", {30'd0, bus_rdata}, {30'd0, exp_read(bus_addr)});
        end
        @(negedge clk);
        bus_wr = 1'b0;
        @(negedge clk);

        done = 1'b1;
        summary();
        $finish;
    end

endmodule